// File: doc/BRIEF.md
# Counter-Mode Cipher Sequencer with Byte Register Window

This block lets a host run a counter-mode encryption pass over a region of byte-wide external memory. The host reaches a small register window over an 8-bit data bus with a 16-bit address and a 2-bit operation code. Through this window it loads a region base address, a byte length, a 128-bit initial counter and a 128-bit key. It then writes a start byte with bit 0 set.

Once started, the block works through the region one 16-byte block at a time. It reads the 16 bytes of the block from memory and asks an external cipher engine for a keystream block. It then writes each byte back to the same address, XOR-ed with the matching keystream byte. A processed-byte count grows by 16 after every block. The block returns to idle once that count is no longer below the programmed length. The cipher round function sits outside the block and answers each request with an acknowledge pulse.

The memory port has a fixed latency: read data arrives on the cycle after a read is issued, and a write completes in the cycle it is issued. While the block is busy, its configuration is frozen. The host can still read it.

Top module: `ctr_cipher_ctrl`

## Requirements
- R1: The bus operation code is 0 for idle, 1 for read and 2 for write. A read drives the addressed register byte on `host_rdata` one cycle later, and the value holds until the next read. Addresses with no register read as 0x00, inside or outside the window 0xFF00..0xFF3F.
- R2: In the idle state, a write updates one register byte, and a read returns it. The region base is at 0xFF02 (low byte) and 0xFF03 (high byte), and the length at 0xFF04/0xFF05 in the same order. The counter occupies 0xFF10+j and the key 0xFF20+j, with byte j held in bits [8j+7:8j].
- R3: A read of 0xFF00 returns the state in bit 0 (0 idle, 1 busy) and zeros above it. Writes to 0xFF00 have no effect.
- R4: In the idle state, a write to 0xFF01 with bit 0 set makes the state busy on the next cycle. With bit 0 clear, the write does nothing. The start register reads as 0x00.
- R5: While busy, every write is ignored, including another start request.
- R6: For block b, the block reads bytes i = 0..15 in ascending order at address base + 16*b + i. It then raises `cph_req` with `cph_in` = counter + b and `cph_key` = key, and holds both steady until `cph_ack`.
- R7: After the acknowledge, byte i is written back to its own address as the read byte XOR `cph_out[8i+7:8i]`, in ascending i.
- R8: After each block the processed count grows by 16. The block continues while the new count is below the length and otherwise returns to idle. At least one block is always processed: a length of 0 or 16 gives 1 block, 17 gives 2 and 48 gives 3. The count is one bit wider than the length, so a length near 0xFFFF does not wrap.
- R9: While idle, `mem_en` and `cph_req` stay low.
- R10: Memory addresses wrap modulo 2^16 past 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host byte address |
| host_op | input | 2 | 0 idle, 1 read, 2 write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after a read |
| cph_req | output | 1 | Keystream request |
| cph_in | output | 128 | Counter block for the cipher |
| cph_key | output | 128 | Cipher key |
| cph_ack | input | 1 | Keystream ready pulse |
| cph_out | input | 128 | Keystream block |

## Verification
Register reads are registered, so each readback is sampled on the falling edge after the clock edge that captured the read. A start shows as status 1 on a read issued in the cycle right after the start write. Memory and cipher results take a variable number of cycles, so the bench polls the status byte until it reads 0 before it compares memory contents, write counts and cipher request counts. A falling-edge monitor checks every memory address and every `cph_in` at the cycle it is presented. All stimulus and sampling happen on falling edges, away from the edge where the design updates.

// File: rtl/ctr_cipher_ctrl.sv
module ctr_cipher_ctrl (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  host_addr,
  input  logic [1:0]   host_op,
  input  logic [7:0]   host_wdata,
  output logic [7:0]   host_rdata,
  output logic         mem_en,
  output logic         mem_we,
  output logic [15:0]  mem_addr,
  output logic [7:0]   mem_wdata,
  input  logic [7:0]   mem_rdata,
  output logic         cph_req,
  output logic [127:0] cph_in,
  output logic [127:0] cph_key,
  input  logic         cph_ack,
  input  logic [127:0] cph_out
);
  localparam logic [1:0]  OP_RD    = 2'd1;
  localparam logic [1:0]  OP_WR    = 2'd2;
  localparam logic [15:0] A_STAT   = 16'hFF00;
  localparam logic [15:0] A_GO     = 16'hFF01;
  localparam logic [15:0] A_BASE   = 16'hFF02;
  localparam logic [15:0] A_LEN    = 16'hFF04;
  localparam logic [11:0] A_CTR_PG = 12'hFF1;
  localparam logic [11:0] A_KEY_PG = 12'hFF2;

  typedef enum logic [2:0] {PH_RD, PH_CAP, PH_CPH, PH_WR, PH_STEP} phase_t;

  logic         state_q;
  phase_t       ph_q;
  logic [3:0]   idx_q;
  logic [15:0]  base_q, len_q, off_q;
  logic [16:0]  done_q;
  logic [127:0] ctr_q, key_q, dat_q, ks_q;
  logic [7:0]   rd_q, rd_byte;

  wire        wr_en   = (host_op == OP_WR) && !state_q;
  wire        go      = wr_en && (host_addr == A_GO) && host_wdata[0];
  wire [16:0] done_nx = done_q + 17'd16;
  wire        more    = done_nx < {1'b0, len_q};
  wire [6:0]  bsel    = {idx_q, 3'b000};
  wire [6:0]  hsel    = {host_addr[3:0], 3'b000};

  assign mem_en     = state_q && (ph_q == PH_RD || ph_q == PH_WR);
  assign mem_we     = state_q && (ph_q == PH_WR);
  assign mem_addr   = base_q + off_q + {12'd0, idx_q};
  assign mem_wdata  = dat_q[bsel +: 8] ^ ks_q[bsel +: 8];
  assign cph_req    = state_q && (ph_q == PH_CPH);
  assign cph_in     = ctr_q + {116'd0, off_q[15:4]};
  assign cph_key    = key_q;
  assign host_rdata = rd_q;

  always_comb begin
    rd_byte = 8'h00;
    case (host_addr)
      A_STAT:        rd_byte = {7'd0, state_q};
      A_BASE:        rd_byte = base_q[7:0];
      A_BASE + 16'd1: rd_byte = base_q[15:8];
      A_LEN:         rd_byte = len_q[7:0];
      A_LEN + 16'd1: rd_byte = len_q[15:8];
      default: begin
        if (host_addr[15:4] == A_CTR_PG)      rd_byte = ctr_q[hsel +: 8];
        else if (host_addr[15:4] == A_KEY_PG) rd_byte = key_q[hsel +: 8];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      ctr_q  <= '0;
      key_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (host_op == OP_RD) rd_q <= rd_byte;
      if (wr_en) begin
        case (host_addr)
          A_BASE:         base_q[7:0]  <= host_wdata;
          A_BASE + 16'd1: base_q[15:8] <= host_wdata;
          A_LEN:          len_q[7:0]   <= host_wdata;
          A_LEN + 16'd1:  len_q[15:8]  <= host_wdata;
          default: begin
            if (host_addr[15:4] == A_CTR_PG)      ctr_q[hsel +: 8] <= host_wdata;
            else if (host_addr[15:4] == A_KEY_PG) key_q[hsel +: 8] <= host_wdata;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      ph_q    <= PH_RD;
      idx_q   <= '0;
      off_q   <= '0;
      done_q  <= '0;
      dat_q   <= '0;
      ks_q    <= '0;
    end else if (!state_q) begin
      if (go) begin
        state_q <= 1'b1;
        ph_q    <= PH_RD;
        idx_q   <= '0;
        off_q   <= '0;
        done_q  <= '0;
      end
    end else begin
      case (ph_q)
        PH_RD:  ph_q <= PH_CAP;
        PH_CAP: begin
          dat_q[bsel +: 8] <= mem_rdata;
          idx_q <= idx_q + 4'd1;
          ph_q  <= (idx_q == 4'hF) ? PH_CPH : PH_RD;
        end
        PH_CPH: begin
          if (cph_ack) begin
            ks_q <= cph_out;
            ph_q <= PH_WR;
          end
        end
        PH_WR: begin
          idx_q <= idx_q + 4'd1;
          if (idx_q == 4'hF) ph_q <= PH_STEP;
        end
        PH_STEP: begin
          done_q <= done_nx;
          ph_q   <= PH_RD;
          if (more) off_q   <= off_q + 16'd16;
          else      state_q <= 1'b0;
        end
        default: ph_q <= PH_RD;
      endcase
    end
  end
endmodule

// File: rtl/ctr_cipher_ctrl_chk.sv
module ctr_cipher_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         state,
  input logic [15:0]  host_addr,
  input logic [1:0]   host_op,
  input logic [7:0]   host_wdata,
  input logic [7:0]   host_rdata,
  input logic         mem_en,
  input logic         mem_we,
  input logic         cph_req,
  input logic         cph_ack,
  input logic [127:0] cph_in,
  input logic [127:0] key,
  input logic [127:0] ctr,
  input logic [15:0]  len,
  input logic [15:0]  base
);
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !state |-> (!mem_en && !cph_req));

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!state && host_op == 2'd2 && host_addr == 16'hFF01 && host_wdata[0]) |=> state);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state |=> ($stable(key) && $stable(ctr) && $stable(len) && $stable(base)));

  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cph_req && !cph_ack) |=> (cph_req && $stable(cph_in)));

  p_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_op == 2'd1 && host_addr == 16'hFF00) |=> (host_rdata == {7'd0, $past(state)}));

  p_write_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
endmodule

bind ctr_cipher_ctrl ctr_cipher_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q),
  .host_addr(host_addr), .host_op(host_op), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .mem_en(mem_en), .mem_we(mem_we),
  .cph_req(cph_req), .cph_ack(cph_ack), .cph_in(cph_in),
  .key(key_q), .ctr(ctr_q), .len(len_q), .base(base_q)
);

// File: tb/ctr_cipher_ctrl_test.sv
`timescale 1ns/1ps
module ctr_cipher_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  host_addr = '0;
  logic [1:0]   host_op = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         mem_en, mem_we;
  logic [15:0]  mem_addr;
  logic [7:0]   mem_wdata;
  logic [7:0]   mem_rdata = '0;
  logic         cph_req;
  logic [127:0] cph_in, cph_key;
  logic         cph_ack = 1'b0;
  logic [127:0] cph_out = '0;

  integer checks = 0, errors = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_m [256];
  integer n_rd = 0, n_wr = 0, n_blk = 0, addr_bad = 0, cin_bad = 0, quiet_bad = 0;
  logic [15:0]  run_base = '0;
  logic [127:0] run_ctr = '0;
  bit expect_idle = 1'b1;
  integer wcnt = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  ctr_cipher_ctrl uut (.*);

  function automatic logic [127:0] ksf(input logic [127:0] c, input logic [127:0] k);
    return c ^ {k[119:0], k[127:120]} ^ {16{8'h3C}};
  endfunction

  always @(posedge clk) begin
    if (mem_en && mem_we)  mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    if (cph_req && !cph_ack) begin
      if (wcnt == 2) begin cph_ack <= 1'b1; cph_out <= ksf(cph_in, cph_key); wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else cph_ack <= 1'b0;
  end

  always @(negedge clk) if (rst_n) begin
    if (mem_en && !mem_we) begin
      if (mem_addr != run_base + n_rd[15:0]) addr_bad = addr_bad + 1;
      n_rd = n_rd + 1;
    end
    if (mem_en && mem_we) begin
      if (mem_addr != run_base + n_wr[15:0]) addr_bad = addr_bad + 1;
      n_wr = n_wr + 1;
    end
    if (cph_req && cph_ack) begin
      if (cph_in != run_ctr + 128'(n_blk)) cin_bad = cin_bad + 1;
      n_blk = n_blk + 1;
    end
    if (expect_idle && (mem_en || cph_req)) quiet_bad = quiet_bad + 1;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); host_op = 2'd2; host_addr = a; host_wdata = d;
    @(negedge clk); host_op = 2'd0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); host_op = 2'd1; host_addr = a;
    @(negedge clk); host_op = 2'd0; d = host_rdata;
  endtask

  localparam int NV = 13;
  localparam logic [47:0] VEC [NV] = '{
    {16'hFF02, 8'h34, 16'hFF02, 8'h34},
    {16'hFF03, 8'h12, 16'hFF03, 8'h12},
    {16'hFF04, 8'h30, 16'hFF04, 8'h30},
    {16'hFF05, 8'h01, 16'hFF05, 8'h01},
    {16'hFF10, 8'hA1, 16'hFF10, 8'hA1},
    {16'hFF1F, 8'hB2, 16'hFF1F, 8'hB2},
    {16'hFF20, 8'hC3, 16'hFF20, 8'hC3},
    {16'hFF2F, 8'hD4, 16'hFF2F, 8'hD4},
    {16'hFF00, 8'h7F, 16'hFF00, 8'h00},
    {16'hFF01, 8'hFE, 16'hFF00, 8'h00},
    {16'hFF01, 8'hFE, 16'hFF01, 8'h00},
    {16'hFF08, 8'h55, 16'hFF08, 8'h00},
    {16'h1234, 8'h77, 16'h1234, 8'h00}
  };

  task automatic run(input logic [15:0] base, input logic [15:0] len, input logic [127:0] ctr,
                     input logic [127:0] key, input int nb, input bit meddle, input string tag);
    int polls;
    logic [127:0] ks;
    logic [7:0] a;
    expect_idle = 1'b1;
    wr(16'hFF02, base[7:0]); wr(16'hFF03, base[15:8]);
    wr(16'hFF04, len[7:0]);  wr(16'hFF05, len[15:8]);
    for (int j = 0; j < 16; j++) begin
      wr(16'hFF10 + 16'(j), ctr[8*j +: 8]);
      wr(16'hFF20 + 16'(j), key[8*j +: 8]);
    end
    for (int j = 0; j < 256; j++) ref_m[j] = mem[j];
    for (int b = 0; b < nb; b++) begin
      ks = ksf(ctr + 128'(b), key);
      for (int i = 0; i < 16; i++) begin
        a = 8'(base + 16'(16*b + i));
        ref_m[a] = ref_m[a] ^ ks[8*i +: 8];
      end
    end
    n_rd = 0; n_wr = 0; n_blk = 0; addr_bad = 0; cin_bad = 0;
    run_base = base; run_ctr = ctr;
    check(quiet_bad == 0, "R9 idle memory quiet", quiet_bad, 0);
    expect_idle = 1'b0;
    wr(16'hFF01, 8'h01);
    rd(16'hFF00, rv);
    check(rv == 8'h01, "R4 start sets busy", rv, 8'h01);
    if (meddle) begin
      wr(16'hFF20, ~key[7:0]);
      wr(16'hFF04, 8'hFF);
      wr(16'hFF01, 8'h01);
    end
    polls = 0;
    rv = 8'h01;
    while (rv[0] && polls < 5000) begin rd(16'hFF00, rv); polls++; end
    check(rv == 8'h00, "R8 returns to idle", rv, 8'h00);
    expect_idle = 1'b1;
    check(n_wr == 16*nb, {"R8 bytes written ", tag}, n_wr, 16*nb);
    check(n_blk == nb, {"R8 blocks ", tag}, n_blk, nb);
    check(addr_bad == 0, {"R6/R10 address order ", tag}, addr_bad, 0);
    check(cin_bad == 0, {"R6 cipher input ", tag}, cin_bad, 0);
    begin
      int bad = 0;
      for (int j = 0; j < 256; j++) if (mem[j] !== ref_m[j]) bad++;
      check(bad == 0, {"R7 memory contents ", tag}, bad, 0);
    end
    if (meddle) begin
      rd(16'hFF20, rv);
      check(rv == key[7:0], "R5 busy write ignored (key)", rv, key[7:0]);
      rd(16'hFF04, rv);
      check(rv == len[7:0], "R5 busy write ignored (length)", rv, len[7:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 256; j++) mem[j] = 8'(j * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_rdata == 8'h00, "R1 reset read data", host_rdata, 0);
    rd(16'hFF00, rv);
    check(rv == 8'h00, "R3 reset status idle", rv, 0);
    rd(16'hFF03, rv);
    check(rv == 8'h00, "R2 reset base register", rv, 0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][47:32], VEC[v][31:24]);
      rd(VEC[v][23:8], rv);
      check(rv == VEC[v][7:0], "R1/R2/R3/R4 register vector", rv, VEC[v][7:0]);
    end
    rd(16'hFF00, rv);
    check(rv == 8'h00, "R4 start with bit0 clear stays idle", rv, 0);
    repeat (4) @(negedge clk);
    check(quiet_bad == 0, "R9 no access while idle", quiet_bad, 0);

    run(16'h0040, 16'd48, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEF0,
        128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 3, 1'b1, "len48");
    run(16'h0010, 16'd0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h1357_9BDF_0246_8ACE_1122_3344_5566_7788, 1, 1'b0, "len0");
    run(16'h00A0, 16'd17, 128'h0000_0000_0000_0000_0000_0000_0000_00FF,
        128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 2, 1'b0, "len17");
    run(16'hFFF8, 16'd32, 128'h1, 128'h2, 2, 1'b0, "wrap");

    repeat (10) @(negedge clk);
    check(quiet_bad == 0, "R9 idle after runs", quiet_bad, 0);
    rd(16'hFF03, rv);
    check(rv == 8'hFF, "R2 base high byte readback", rv, 8'hFF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule